// File: doc/BRIEF.md
# Guarded 64-bit Configuration Register Writer

This block holds a small bank of 64-bit configuration registers. Each register is addressed by a 32-bit index. Every write request is screened before it is committed. A request carries an index, a high data word, a low data word, the requester's privilege level, mode flags and a lock flag. The block either stores the 64-bit value or reports exactly one fault code. When the write targets one of the memory-type-range slots, it also emits a one-cycle TLB-invalidate pulse that covers global entries.

Writes are serializing. After a request is accepted, the input side stays closed until the commit has happened and a one-cycle `done` has been issued. A combinational read-back port lets the surrounding logic, or a test, inspect any slot. Instruction decode, the TLB itself and exception delivery are handled elsewhere.

Top module: `cfgreg_wr_unit`

## Requirements
- R1: After reset every slot reads zero, `req_ready` is 1, and `done` and `tlb_inval` are 0.
- R2: A write that raises no fault stores `req_data_hi[31:0]` in bits 63:32 and `req_data_lo[31:0]` in bits 31:0 of the selected slot. The new value is visible on `rd_data` once `done` has been seen.
- R3: Bits 63:32 of `req_index`, `req_data_hi` and `req_data_lo` are ignored.
- R4: A request with `req_lock`=1 reports fault code 1 (invalid-opcode). This fault takes priority over every other fault, and the bank is left unchanged.
- R5: If neither `req_real` nor `req_v86` is set and `req_cpl` is not 0, the request reports fault code 2 (general-protection, error code 0). With `req_real`=1 any `req_cpl` is allowed.
- R6: With `req_v86`=1 the request always reports fault code 2, even when `req_cpl` is 0 or `req_real` is 1.
- R7: Implemented indices are 0x200+k for slots k=0..7. Any other index reports fault code 2 and leaves every slot unchanged.
- R8: Even slots reserve mask 0xFF00_0000_0000_0000 and odd slots reserve mask 0x0000_0000_0000_0F00. A value with (data AND mask) nonzero reports fault code 2 and is not stored, so no slot ever holds a reserved bit.
- R9: Fault priority is: lock, then privilege/mode, then unimplemented index, then reserved bits. Fault code 0 means success.
- R10: A successful write to slot 4 or 5 (index 0x204, 0x205) raises `tlb_inval` and `tlb_global` for exactly the `done` cycle. A faulting write or a write to any other slot leaves both low.
- R11: An accept edge (`req_valid` and `req_ready` both high) drops `req_ready` in the next cycle. `done` is high in the second cycle after the accept edge, for one cycle, and `req_ready` returns in the cycle after that. `req_valid` is ignored while `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_index | input | 64 | Register index; only bits 31:0 are used |
| req_data_hi | input | 64 | High data word; only bits 31:0 are used |
| req_data_lo | input | 64 | Low data word; only bits 31:0 are used |
| req_cpl | input | 2 | Current privilege level |
| req_real | input | 1 | Real-address mode flag |
| req_v86 | input | 1 | Virtual-8086 mode flag |
| req_lock | input | 1 | Lock-prefix flag |
| done | output | 1 | One-cycle completion strobe |
| fault_code | output | 2 | 0 none, 1 invalid-opcode, 2 general-protection; valid with `done` |
| tlb_inval | output | 1 | One-cycle TLB-invalidate pulse |
| tlb_global | output | 1 | Global entries included in the invalidate |
| rd_index | input | 32 | Read-back index |
| rd_data | output | 64 | Read-back value; zero for an unimplemented index |

## Verification
Some properties are checked by assertions on every cycle. These are the handshake shape (ready drops after an accept, `done` lands two edges later and then reopens the input), that a TLB pulse only appears with a successful `done`, that no slot ever holds a reserved bit, and that slots change only on a write enable. The fault arbitration order, the split of the data words into halves, the ignored upper operand bits and requests held high while busy can only be shown by the bench scenarios. These compare fault codes and read-back values against a model.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    localparam int IDX_W  = 32;
    localparam int HALF_W = 32;
    localparam int DATA_W = 64;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_UD   = 2'd1,
        FLT_GP   = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RESP  = 2'd2
    } seq_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic [1:0]        cpl;
        logic              real_m;
        logic              v86_m;
        logic              lock;
    } wreq_t;

    // Reserved-bit mask of a slot: even and odd slots differ.
    function automatic logic [DATA_W-1:0] rsvd_of(int slot);
        return (slot % 2 == 0) ? 64'hFF00_0000_0000_0000
                               : 64'h0000_0000_0000_0F00;
    endfunction

endpackage

// File: rtl/cfgreg_check.sv
module cfgreg_check
    import cfgreg_pkg::*;
#(
    parameter int                 NUM_REGS   = 8,
    parameter logic [IDX_W-1:0]   BASE_IDX   = 32'h0000_0200,
    parameter logic [NUM_REGS-1:0] MTRR_SLOTS = 8'b0011_0000,
    localparam int                SLOT_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  wreq_t             req,
    output fault_e            fault,
    output logic [SLOT_W-1:0] slot,
    output logic              is_mtrr
);

    logic [IDX_W-1:0]  offset;
    logic              hit;
    logic [DATA_W-1:0] mask;
    logic              priv_ok;

    assign offset = req.idx - BASE_IDX;
    assign hit    = (req.idx >= BASE_IDX) && (offset < IDX_W'(NUM_REGS));
    assign slot   = offset[SLOT_W-1:0];

    always_comb begin
        mask = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (SLOT_W'(k) == slot) mask = rsvd_of(k);
        end
    end

    assign is_mtrr = hit && MTRR_SLOTS[slot];
    assign priv_ok = !req.v86_m && (req.real_m || req.cpl == 2'd0);

    // Fixed arbitration: lock, privilege/mode, index, reserved bits.
    always_comb begin
        if (req.lock)                    fault = FLT_UD;
        else if (!priv_ok)               fault = FLT_GP;
        else if (!hit)                   fault = FLT_GP;
        else if ((req.data & mask) != 0) fault = FLT_GP;
        else                             fault = FLT_NONE;
    end

endmodule

// File: rtl/cfgreg_bank.sv
module cfgreg_bank
    import cfgreg_pkg::*;
#(
    parameter int  NUM_REGS = 8,
    localparam int SLOT_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rhit,
    input  logic [SLOT_W-1:0] rslot,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                regs[g] <= '0;
            else if (we && wslot == SLOT_W'(g))     regs[g] <= wdata;
        end

        // R8: a slot never holds a reserved bit
        a_r8_no_rsvd_held: assert property (@(posedge clk) disable iff (rst)
            (regs[g] & rsvd_of(g)) == '0);

        // R7: a slot changes only under a write enable
        a_r7_hold_without_we: assert property (@(posedge clk) disable iff (rst)
            !we |=> $stable(regs[g]));
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rhit && rslot == SLOT_W'(k)) rdata = regs[k];
        end
    end

endmodule

// File: rtl/cfgreg_seq.sv
module cfgreg_seq
    import cfgreg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  wreq_t  req_in,
    input  fault_e fault_in,
    input  logic   mtrr_in,
    output logic   req_ready,
    output wreq_t  cap,
    output logic   we,
    output logic   done,
    output fault_e fault_out,
    output logic   tlb_pulse
);

    seq_e state;

    assign req_ready = (state == ST_IDLE);
    assign we        = (state == ST_CHECK) && (fault_in == FLT_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cap       <= '0;
            done      <= 1'b0;
            fault_out <= FLT_NONE;
            tlb_pulse <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    done      <= 1'b0;
                    tlb_pulse <= 1'b0;
                    if (req_valid) begin
                        cap   <= req_in;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    done      <= 1'b1;
                    fault_out <= fault_in;
                    tlb_pulse <= (fault_in == FLT_NONE) && mtrr_in;
                    state     <= ST_RESP;
                end
                default: begin
                    done      <= 1'b0;
                    fault_out <= FLT_NONE;
                    tlb_pulse <= 1'b0;
                    state     <= ST_IDLE;
                end
            endcase
        end
    end

    // R11: input closes right after an accept
    a_r11_close_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R11: done only two edges after an accept
    a_r11_done_after_accept: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(req_valid && req_ready, 2));

    // R11: done lasts one cycle and reopens the input
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

    // R10: invalidate only with a successful completion
    a_r10_tlb_on_success: assert property (@(posedge clk) disable iff (rst)
        tlb_pulse |-> (done && fault_out == FLT_NONE));

endmodule

// File: rtl/cfgreg_wr_unit.sv
module cfgreg_wr_unit
    import cfgreg_pkg::*;
#(
    parameter int                  NUM_REGS   = 8,
    parameter logic [31:0]         BASE_IDX   = 32'h0000_0200,
    parameter logic [NUM_REGS-1:0] MTRR_SLOTS = 8'b0011_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] req_index,
    input  logic [63:0] req_data_hi,
    input  logic [63:0] req_data_lo,
    input  logic [1:0]  req_cpl,
    input  logic        req_real,
    input  logic        req_v86,
    input  logic        req_lock,
    output logic        done,
    output logic [1:0]  fault_code,
    output logic        tlb_inval,
    output logic        tlb_global,
    input  logic [31:0] rd_index,
    output logic [63:0] rd_data
);

    localparam int SLOT_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    wreq_t             req_in, cap;
    fault_e            fault_c, fault_q;
    logic [SLOT_W-1:0] wslot, rslot;
    logic              mtrr_c, we, tlb_q, rhit;
    logic [IDX_W-1:0]  roff;

    // Upper operand halves are dropped here.
    assign req_in = '{idx:    req_index[IDX_W-1:0],
                      data:   {req_data_hi[HALF_W-1:0], req_data_lo[HALF_W-1:0]},
                      cpl:    req_cpl,
                      real_m: req_real,
                      v86_m:  req_v86,
                      lock:   req_lock};

    cfgreg_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .fault_in  (fault_c),
        .mtrr_in   (mtrr_c),
        .req_ready (req_ready),
        .cap       (cap),
        .we        (we),
        .done      (done),
        .fault_out (fault_q),
        .tlb_pulse (tlb_q)
    );

    cfgreg_check #(
        .NUM_REGS   (NUM_REGS),
        .BASE_IDX   (BASE_IDX),
        .MTRR_SLOTS (MTRR_SLOTS)
    ) u_check (
        .req     (cap),
        .fault   (fault_c),
        .slot    (wslot),
        .is_mtrr (mtrr_c)
    );

    assign roff  = rd_index - BASE_IDX;
    assign rhit  = (rd_index >= BASE_IDX) && (roff < IDX_W'(NUM_REGS));
    assign rslot = roff[SLOT_W-1:0];

    cfgreg_bank #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .wslot (wslot),
        .wdata (cap.data),
        .rhit  (rhit),
        .rslot (rslot),
        .rdata (rd_data)
    );

    assign fault_code = fault_q;
    assign tlb_inval  = tlb_q;
    assign tlb_global = tlb_q;

    // R9: a fault code is only reported alongside done
    a_r9_fault_with_done: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 2'd0) |-> done);

endmodule

// File: tb/cfgreg_wr_unit_tb_top.sv
`timescale 1ns/1ps
module cfgreg_wr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_index, req_data_hi, req_data_lo;
    logic [1:0]  req_cpl;
    logic        req_real, req_v86, req_lock;
    logic        done;
    logic [1:0]  fault_code;
    logic        tlb_inval, tlb_global;
    logic [31:0] rd_index;
    logic [63:0] rd_data;

    int total = 0;
    int bad   = 0;
    logic [63:0] model [8];

    always #2.5 clk = ~clk;

    cfgreg_wr_unit dut_i (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_index (req_index), .req_data_hi (req_data_hi), .req_data_lo (req_data_lo),
        .req_cpl (req_cpl), .req_real (req_real), .req_v86 (req_v86), .req_lock (req_lock),
        .done (done), .fault_code (fault_code),
        .tlb_inval (tlb_inval), .tlb_global (tlb_global),
        .rd_index (rd_index), .rd_data (rd_data)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mask_of(int slot);
        return (slot % 2 == 0) ? 64'hFF00_0000_0000_0000 : 64'h0000_0000_0000_0F00;
    endfunction

    function automatic logic idx_ok(logic [31:0] idx);
        return idx >= 32'h200 && idx <= 32'h207;
    endfunction

    function automatic logic [1:0] exp_fault(logic lock, logic v86, logic rl,
                                             logic [1:0] cpl, logic [31:0] idx,
                                             logic [63:0] data);
        if (lock) return 2'd1;
        if (v86 || (!rl && cpl != 2'd0)) return 2'd2;
        if (!idx_ok(idx)) return 2'd2;
        if ((data & mask_of(int'(idx - 32'h200))) != 0) return 2'd2;
        return 2'd0;
    endfunction

    task automatic readback(string tag, logic [31:0] idx, logic [63:0] exp);
        rd_index = idx;
        #0.5;
        check(tag, rd_data, exp);
    endtask

    task automatic do_req(string tag, logic [63:0] idx, logic [63:0] hi, logic [63:0] lo,
                          logic [1:0] cpl, logic rl, logic v86, logic lock, logic hold);
        logic [31:0] i32;
        logic [63:0] d;
        logic [1:0]  ef;
        logic        mt;
        i32 = idx[31:0];
        d   = {hi[31:0], lo[31:0]};
        ef  = exp_fault(lock, v86, rl, cpl, i32, d);
        mt  = (ef == 2'd0) && (i32 == 32'h204 || i32 == 32'h205);
        @(negedge clk);
        check({tag, " R11 ready idle"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_index = idx; req_data_hi = hi; req_data_lo = lo;
        req_cpl = cpl; req_real = rl; req_v86 = v86; req_lock = lock;
        @(negedge clk);
        check({tag, " R11 ready drop"}, 64'(req_ready), 64'd0);
        if (hold) begin
            // R11: a second request held during busy must be ignored
            req_index = 64'h201; req_data_hi = 64'h0; req_data_lo = 64'hDEAD_0000;
            req_cpl = 2'd0; req_real = 1'b0; req_v86 = 1'b0; req_lock = 1'b0;
        end else begin
            req_valid = 1'b0;
        end
        @(negedge clk);
        check({tag, " R11 done"}, 64'(done), 64'd1);
        check({tag, " R9 fault"}, 64'(fault_code), 64'(ef));
        check({tag, " R10 tlb"}, 64'(tlb_inval), 64'(mt));
        check({tag, " R10 global"}, 64'(tlb_global), 64'(mt));
        req_valid = 1'b0;
        @(negedge clk);
        check({tag, " R11 reopen"}, 64'({req_ready, done, tlb_inval}), 64'b100);
        if (ef == 2'd0) model[i32 - 32'h200] = d;
        if (idx_ok(i32)) readback({tag, " R2 readback"}, i32, model[i32 - 32'h200]);
        if (hold) readback({tag, " R11 busy ignored"}, 32'h201, model[1]);
    endtask

    initial begin
        #(200000 * 5.0);
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        process::self().srandom(32'h1234_5678);
        req_valid = 0; req_index = 0; req_data_hi = 0; req_data_lo = 0;
        req_cpl = 0; req_real = 0; req_v86 = 0; req_lock = 0; rd_index = 0;
        for (int k = 0; k < 8; k++) model[k] = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        check("R1 ready", 64'(req_ready), 64'd1);
        check("R1 done", 64'({done, tlb_inval}), 64'd0);
        for (int k = 0; k < 8; k++) readback("R1 slot zero", 32'h200 + k, 64'd0);

        // R2 half placement
        do_req("R2 plain", 64'h201, 64'h1234_5678, 64'h9ABC_D0EF & 64'hFFFF_F0FF, 2'd0, 0, 0, 0, 0);
        // R3 upper bits ignored
        do_req("R3 upper", 64'hFFFF_0000_0000_0203, 64'hAAAA_BBBB_0000_1111,
               64'hCCCC_DDDD_2222_3333, 2'd0, 0, 0, 0, 0);
        // R4 lock beats everything
        do_req("R4 lock", 64'h999, 64'hFFFF_FFFF, 64'h0, 2'd3, 0, 1, 1, 0);
        do_req("R4 lock ok", 64'h202, 64'h1, 64'h1, 2'd0, 0, 0, 1, 0);
        // R5 privilege
        do_req("R5 cpl3", 64'h202, 64'h5, 64'h5, 2'd3, 0, 0, 0, 0);
        do_req("R5 real cpl3", 64'h202, 64'h5, 64'h5, 2'd3, 1, 0, 0, 0);
        // R6 v86
        do_req("R6 v86", 64'h206, 64'h7, 64'h7, 2'd0, 1, 1, 0, 0);
        // R7 unimplemented
        do_req("R7 low", 64'h1FF, 64'h1, 64'h1, 2'd0, 0, 0, 0, 0);
        do_req("R7 high", 64'h208, 64'h1, 64'h1, 2'd0, 0, 0, 0, 0);
        // R8 reserved bits
        do_req("R8 even", 64'h200, 64'h0100_0000, 64'h0, 2'd0, 0, 0, 0, 0);
        do_req("R8 odd", 64'h201, 64'h0, 64'h0000_0100, 2'd0, 0, 0, 0, 0);
        // R9 order: privilege before index
        do_req("R9 priv>idx", 64'h300, 64'h0, 64'h0, 2'd1, 0, 0, 0, 0);
        // R10 range slots
        do_req("R10 slot4", 64'h204, 64'h00AB_0000, 64'h1, 2'd0, 0, 0, 0, 0);
        do_req("R10 slot5", 64'h205, 64'h1, 64'h2, 2'd0, 1, 0, 0, 0);
        do_req("R10 slot5 bad", 64'h205, 64'h0, 64'h0F00, 2'd0, 0, 0, 0, 0);
        // R11 busy-held request
        do_req("R11 hold", 64'h207, 64'h3, 64'h4, 2'd0, 0, 0, 0, 1);

        for (int n = 0; n < 300; n++) begin
            logic [63:0] idx, hi, lo;
            logic [3:0]  r;
            r   = 4'($urandom);
            idx = {32'($urandom), 32'h0};
            idx[31:0] = (r < 13) ? 32'h200 + 32'($urandom_range(0, 8)) : 32'($urandom);
            hi  = {32'($urandom), 32'($urandom)};
            lo  = {32'($urandom), 32'($urandom)};
            if ($urandom_range(0, 1) == 0) begin
                hi[31:24] = 8'h0; lo[11:8] = 4'h0;
            end
            do_req("rand", idx, hi, lo,
                   ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd0,
                   $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0,
                   $urandom_range(0, 15) == 0, $urandom_range(0, 9) == 0);
        end
        for (int k = 0; k < 8; k++) readback("R2 final", 32'h200 + k, model[k]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule